// File: doc/BRIEF.md
# Requestor-to-domain association table

This block holds the table that tells a memory protection checker which memory domains a given requestor may use. A configuration port writes and reads 32-bit words of the table. A lookup port takes a requestor ID and, one clock later, returns the matching domain set. In the bitmap layout, that set is a domain mask. In the permission layout, it is a per-domain read grant and a per-domain write grant.

Three layouts are selected at elaboration by the `LAYOUT` parameter. Layout 0, the bitmap layout, keeps one domain mask of up to 63 bits per requestor. Each requestor row also has a sticky row lock. Layout 2, the permission layout, keeps one row per domain. Each row holds a read bit and a write bit for every requestor. Layout 1, the direct layout, has no table: requestor i maps to domain i alone. A column-lock register, frozen by its own sticky bit, protects chosen domains against later edits in every row.

The address map is shared by all layouts:
- Word 0 holds the column-lock freeze bit at bit 0 and domains 0..30 at bits 31:1.
- Word 1 holds domains 31..62 at bits 31:0.
- Words 2 and 3 are reserved.
- Table row r occupies word 4+2r (low word) and word 5+2r (high word).

Top module: `req_domain_map`

## Requirements
- R1: After reset, every configuration word reads 0. In the bitmap and permission layouts, every lookup returns all-zero mask, read and write vectors.
- R2: In the bitmap layout, the low word of row r (address 4+2r) holds domains 0..30 at bits 30:0, and the high word (address 5+2r) holds domains 31..62 at bits 31:0. A lookup of requestor r returns that mask, and both the read and write grant vectors equal the mask.
- R3: Mask bits for domains at or above NUM_DOM are never stored. They read 0 and never appear on the lookup outputs.
- R4: Bit 31 of a bitmap row's low word is that row's lock. Once it is 1, writes to both words of the row leave the row unchanged until reset.
- R5: In the permission layout, row m belongs to domain m. For requestor s below 16, the read grant is bit 2s and the write grant is bit 2s+1 of the low word. For requestor s of 16 or above, the grants sit at bits 2(s-16) and 2(s-16)+1 of the high word. The lookup mask is the OR of the two grants.
- R6: While column-lock bit m is 1, a write never changes bit m of any bitmap row. In the permission layout, it never changes any bit of domain m's row.
- R7: Column-lock bit m sits at word 0 bit m+1 for m below 31, and at word 1 bit m-31 otherwise. Once word 0 bit 0 (the freeze bit) is 1, writes to words 0 and 1 are ignored.
- R8: Lock bits (row locks and the freeze bit) reset to 0 and are set by writing 1. Writing 0 never clears them.
- R9: In the direct layout, a lookup of requestor i returns a mask with only bit i set, and equal read and write grants. All configuration words read 0 and writes have no effect.
- R10: A lookup with a requestor ID at or above NUM_REQ returns all-zero vectors. In the direct layout, an ID at or above NUM_DOM also returns all-zero vectors.
- R11: Read data and lookup results appear on the cycle after the address or ID is presented. They reflect the table before any write accepted in that same cycle. Reserved words and rows beyond the table read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_waddr | input | ADDR_W | Configuration write word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | ADDR_W | Configuration read word address |
| cfg_rdata | output | 32 | Registered configuration read data |
| lk_rid | input | RID_W | Requestor ID to look up |
| lk_mask | output | NUM_DOM | Registered domain association mask |
| lk_rd | output | NUM_DOM | Registered per-domain read grant |
| lk_wr | output | NUM_DOM | Registered per-domain write grant |

## Verification
A configuration write and a lookup or read of the same row can land in the same clock cycle. The same holds for a column-lock update and a table write aimed at a column it protects in the very next cycle. The bench provokes both cases deliberately. It writes row 3 while reading and looking up row 3, and it arms a column lock just before writing into that column. The behavioural reference model computes every expected output from its state before it applies that cycle's write. A same-cycle hazard therefore shows up as a mismatch either in the cycle of the write or in the cycle after it.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

   localparam int LAYOUT_BITMAP = 0;
   localparam int LAYOUT_DIRECT = 1;
   localparam int LAYOUT_PERM   = 2;
   localparam int TBL_BASE      = 4;

   // n ones from bit 0 upward
   function automatic logic [63:0] low_ones(input int n);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = (i < n);
      return r;
   endfunction

   // place a 32-bit word onto its domain positions
   function automatic logic [62:0] spread_dom(input logic hi, input logic [31:0] d);
      return hi ? {d, 31'b0} : {32'b0, d[30:0]};
   endfunction

   // domain positions covered by the low or high word
   function automatic logic [62:0] dom_sel(input logic hi);
      return hi ? {32'hFFFF_FFFF, 31'b0} : {32'b0, 31'h7FFF_FFFF};
   endfunction

endpackage

// File: rtl/rdm_col_lock.sv
module rdm_col_lock import rdm_pkg::*; #(
   parameter int NUM_DOM = 63
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [62:0] col_mask,
   output logic        col_frozen
);

   localparam logic [63:0] IMPL64 = low_ones(NUM_DOM);
   localparam logic [62:0] IMPL   = IMPL64[62:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_mask   <= '0;
         col_frozen <= 1'b0;
      end else if (!col_frozen) begin
         if (wr_lo) begin
            col_mask   <= (col_mask & ~dom_sel(1'b0)) |
                          (spread_dom(1'b0, {1'b0, wdata[31:1]}) & IMPL);
            col_frozen <= wdata[0];
         end else if (wr_hi) begin
            col_mask   <= (col_mask & ~dom_sel(1'b1)) |
                          (spread_dom(1'b1, wdata) & IMPL);
         end
      end
   end

   // R7
   frozen_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_frozen |=> $stable(col_mask));

   // R8
   frozen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_frozen |=> col_frozen);

endmodule

// File: rtl/rdm_table.sv
module rdm_table import rdm_pkg::*; #(
   parameter int LAYOUT  = LAYOUT_BITMAP,
   parameter int NUM_REQ = 32,
   parameter int NUM_DOM = 63,
   parameter int RID_W   = 16,
   parameter int IDX_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_hi,
   input  logic [31:0]        wr_data,
   input  logic [62:0]        col_mask,
   input  logic [IDX_W-1:0]   rd_idx,
   input  logic               rd_hi,
   output logic [31:0]        rd_word,
   input  logic [RID_W-1:0]   lk_rid,
   output logic [NUM_DOM-1:0] lk_mask,
   output logic [NUM_DOM-1:0] lk_rd,
   output logic [NUM_DOM-1:0] lk_wr
);

   localparam int RW = $clog2(NUM_REQ);

   logic l_ok;
   logic [RW-1:0] li;
   assign l_ok = lk_rid < RID_W'(NUM_REQ);
   assign li   = lk_rid[RW-1:0];

   if (LAYOUT == LAYOUT_BITMAP) begin : g_bitmap
      localparam logic [63:0] IMPL64 = low_ones(NUM_DOM);

      logic [62:0]        row_mask [NUM_REQ];
      logic [NUM_REQ-1:0] row_lock;
      logic [RW-1:0]      wi, ri;
      logic               w_ok, r_ok;
      logic [62:0]        wmask;

      assign wi    = wr_idx[RW-1:0];
      assign ri    = rd_idx[RW-1:0];
      assign w_ok  = wr_en && (wr_idx < IDX_W'(NUM_REQ));
      assign r_ok  = rd_idx < IDX_W'(NUM_REQ);
      assign wmask = dom_sel(wr_hi) & ~col_mask & IMPL64[62:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_REQ; i++) row_mask[i] <= '0;
            row_lock <= '0;
         end else if (w_ok && !row_lock[wi]) begin
            row_mask[wi] <= (row_mask[wi] & ~wmask) | (spread_dom(wr_hi, wr_data) & wmask);
            if (!wr_hi && wr_data[31]) row_lock[wi] <= 1'b1;
         end
      end

      assign rd_word = !r_ok ? '0 :
                       rd_hi ? row_mask[ri][62:31] : {row_lock[ri], row_mask[ri][30:0]};
      assign lk_mask = l_ok ? row_mask[li][NUM_DOM-1:0] : '0;
      assign lk_rd   = lk_mask;
      assign lk_wr   = lk_mask;

      // R8
      row_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (row_lock & $past(row_lock)) == $past(row_lock));

      // R4
      locked_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (w_ok && row_lock[wi]) |=> row_mask[$past(wi)] == $past(row_mask[wi]));

   end else begin : g_perm
      localparam int DW = $clog2(NUM_DOM);
      localparam logic [63:0] IMPL64 = low_ones(2 * NUM_REQ);

      logic [63:0]        row_perm [NUM_DOM];
      logic [NUM_DOM-1:0] colv;
      logic [DW-1:0]      di, ri;
      logic               w_ok, r_ok;
      logic [5:0]         rb;

      assign colv = col_mask[NUM_DOM-1:0];
      assign di   = wr_idx[DW-1:0];
      assign ri   = rd_idx[DW-1:0];
      assign w_ok = wr_en && (wr_idx < IDX_W'(NUM_DOM));
      assign r_ok = rd_idx < IDX_W'(NUM_DOM);
      assign rb   = 6'({li, 1'b0});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NUM_DOM; i++) row_perm[i] <= '0;
         end else if (w_ok && !colv[di]) begin
            row_perm[di] <= (wr_hi ? {wr_data, row_perm[di][31:0]}
                                   : {row_perm[di][63:32], wr_data}) & IMPL64;
         end
      end

      assign rd_word = !r_ok ? '0 : rd_hi ? row_perm[ri][63:32] : row_perm[ri][31:0];

      always_comb begin
         for (int m = 0; m < NUM_DOM; m++) begin
            lk_rd[m] = l_ok & row_perm[m][rb];
            lk_wr[m] = l_ok & row_perm[m][rb | 6'd1];
         end
      end
      assign lk_mask = lk_rd | lk_wr;

      // R6
      col_locked_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (w_ok && colv[di]) |=> row_perm[$past(di)] == $past(row_perm[di]));
   end

endmodule

// File: rtl/req_domain_map.sv
module req_domain_map import rdm_pkg::*; #(
   parameter int LAYOUT  = LAYOUT_BITMAP,
   parameter int NUM_REQ = 32,
   parameter int NUM_DOM = 63,
   parameter int RID_W   = 16,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [ADDR_W-1:0]  cfg_waddr,
   input  logic [31:0]        cfg_wdata,
   input  logic [ADDR_W-1:0]  cfg_raddr,
   output logic [31:0]        cfg_rdata,
   input  logic [RID_W-1:0]   lk_rid,
   output logic [NUM_DOM-1:0] lk_mask,
   output logic [NUM_DOM-1:0] lk_rd,
   output logic [NUM_DOM-1:0] lk_wr
);

   localparam int IDX_W = ADDR_W - 1;
   localparam int ROWS  = (LAYOUT == LAYOUT_PERM) ? NUM_DOM : NUM_REQ;

   if (LAYOUT != LAYOUT_BITMAP && LAYOUT != LAYOUT_DIRECT && LAYOUT != LAYOUT_PERM) begin : g_bad_layout
      $error("LAYOUT must be 0, 1 or 2");
   end
   if (NUM_DOM < 2 || NUM_DOM > 63) begin : g_bad_dom
      $error("NUM_DOM must lie in 2..63");
   end
   if (NUM_REQ < 2 || NUM_REQ >= (1 << RID_W)) begin : g_bad_req
      $error("NUM_REQ must be at least 2 and below 2**RID_W");
   end
   if (LAYOUT == LAYOUT_PERM && NUM_REQ > 32) begin : g_bad_perm
      $error("permission layout holds at most 32 requestors");
   end
   if (TBL_BASE + 2 * ROWS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the table");
   end

   logic [62:0]        col_mask;
   logic               col_frozen;
   logic [31:0]        tbl_word;
   logic [NUM_DOM-1:0] nx_mask, nx_rd, nx_wr;

   if (LAYOUT == LAYOUT_DIRECT) begin : g_direct
      assign col_mask   = '0;
      assign col_frozen = 1'b0;
      assign tbl_word   = '0;
      always_comb begin
         for (int m = 0; m < NUM_DOM; m++)
            nx_mask[m] = (lk_rid < RID_W'(NUM_REQ)) && (lk_rid == RID_W'(m));
      end
      assign nx_rd = nx_mask;
      assign nx_wr = nx_mask;

      // R9
      direct_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(lk_mask));
   end else begin : g_table
      logic [ADDR_W-1:0] woff, roff;
      logic              w_tbl;

      assign woff  = cfg_waddr - ADDR_W'(TBL_BASE);
      assign roff  = cfg_raddr - ADDR_W'(TBL_BASE);
      assign w_tbl = cfg_wr_en && (cfg_waddr >= ADDR_W'(TBL_BASE));

      rdm_col_lock #(.NUM_DOM(NUM_DOM)) u_col (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_lo     (cfg_wr_en && cfg_waddr == '0),
         .wr_hi     (cfg_wr_en && cfg_waddr == ADDR_W'(1)),
         .wdata     (cfg_wdata),
         .col_mask  (col_mask),
         .col_frozen(col_frozen)
      );

      rdm_table #(
         .LAYOUT (LAYOUT),
         .NUM_REQ(NUM_REQ),
         .NUM_DOM(NUM_DOM),
         .RID_W  (RID_W),
         .IDX_W  (IDX_W)
      ) u_tbl (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (w_tbl),
         .wr_idx  (woff[ADDR_W-1:1]),
         .wr_hi   (woff[0]),
         .wr_data (cfg_wdata),
         .col_mask(col_mask),
         .rd_idx  (roff[ADDR_W-1:1]),
         .rd_hi   (roff[0]),
         .rd_word (tbl_word),
         .lk_rid  (lk_rid),
         .lk_mask (nx_mask),
         .lk_rd   (nx_rd),
         .lk_wr   (nx_wr)
      );
   end

   logic [31:0] rd_next;
   always_comb begin
      if (cfg_raddr == '0)                          rd_next = {col_mask[30:0], col_frozen};
      else if (cfg_raddr == ADDR_W'(1))             rd_next = col_mask[62:31];
      else if (cfg_raddr >= ADDR_W'(TBL_BASE))      rd_next = tbl_word;
      else                                          rd_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
         lk_mask   <= '0;
         lk_rd     <= '0;
         lk_wr     <= '0;
      end else begin
         cfg_rdata <= rd_next;
         lk_mask   <= nx_mask;
         lk_rd     <= nx_rd;
         lk_wr     <= nx_wr;
      end
   end

   // R10
   oor_rid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_rid >= RID_W'(NUM_REQ)) |=> (lk_mask == '0 && lk_rd == '0 && lk_wr == '0));

   // R11
   reserved_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_raddr == ADDR_W'(2) || cfg_raddr == ADDR_W'(3)) |=> cfg_rdata == '0);

endmodule

// File: tb/sim_req_domain_map.sv
`timescale 1ns/1ps
module sim_req_domain_map;
   localparam int NR = 32;
   localparam int ND = 40;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic        we;
   logic [7:0]  wa, ra;
   logic [31:0] wd;
   logic [15:0] rid;

   logic [31:0]   rdat [3];
   logic [ND-1:0] omask [3];
   logic [ND-1:0] ord [3];
   logic [ND-1:0] owr [3];

   req_domain_map #(.LAYOUT(0), .NUM_REQ(NR), .NUM_DOM(ND)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(we), .cfg_waddr(wa), .cfg_wdata(wd),
      .cfg_raddr(ra), .cfg_rdata(rdat[0]), .lk_rid(rid),
      .lk_mask(omask[0]), .lk_rd(ord[0]), .lk_wr(owr[0]));
   req_domain_map #(.LAYOUT(2), .NUM_REQ(NR), .NUM_DOM(ND)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(we), .cfg_waddr(wa), .cfg_wdata(wd),
      .cfg_raddr(ra), .cfg_rdata(rdat[1]), .lk_rid(rid),
      .lk_mask(omask[1]), .lk_rd(ord[1]), .lk_wr(owr[1]));
   req_domain_map #(.LAYOUT(1), .NUM_REQ(NR), .NUM_DOM(ND)) u2 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(we), .cfg_waddr(wa), .cfg_wdata(wd),
      .cfg_raddr(ra), .cfg_rdata(rdat[2]), .lk_rid(rid),
      .lk_mask(omask[2]), .lk_rd(ord[2]), .lk_wr(owr[2]));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   logic [62:0] bm [NR];
   logic        bml [NR];
   logic [63:0] pm [ND];
   logic [62:0] c0, c1;
   logic        c0l, c1l;

   function automatic logic [31:0] col_word(logic [62:0] c, logic l, logic [7:0] a);
      logic [31:0] r = '0;
      if (a == 0) begin
         r[0] = l;
         for (int j = 0; j < 31; j++) r[j+1] = c[j];
      end else begin
         for (int k = 0; k < 32; k++) r[k] = c[31+k];
      end
      return r;
   endfunction

   function automatic logic [31:0] exp_rd(int lay, logic [7:0] a);
      logic [31:0] r = '0;
      int idx;
      if (lay == 1) return '0;
      if (a < 2) return (lay == 0) ? col_word(c0, c0l, a) : col_word(c1, c1l, a);
      if (a < 4) return '0;
      idx = (int'(a) - 4) / 2;
      if (lay == 0) begin
         if (idx >= NR) return '0;
         if (a[0] == 1'b0) begin
            for (int j = 0; j < 31; j++) r[j] = bm[idx][j];
            r[31] = bml[idx];
         end else begin
            for (int k = 0; k < 32; k++) r[k] = bm[idx][31+k];
         end
      end else begin
         if (idx >= ND) return '0;
         r = a[0] ? pm[idx][63:32] : pm[idx][31:0];
      end
      return r;
   endfunction

   task automatic model_write(logic [7:0] a, logic [31:0] d);
      int idx;
      if (a == 0) begin
         if (!c0l) begin
            for (int j = 0; j < 31; j++) c0[j] = (j < ND) ? d[j+1] : 1'b0;
            if (d[0]) c0l = 1'b1;
         end
         if (!c1l) begin
            for (int j = 0; j < 31; j++) c1[j] = (j < ND) ? d[j+1] : 1'b0;
            if (d[0]) c1l = 1'b1;
         end
      end else if (a == 1) begin
         if (!c0l) for (int k = 0; k < 32; k++) c0[31+k] = (31 + k < ND) ? d[k] : 1'b0;
         if (!c1l) for (int k = 0; k < 32; k++) c1[31+k] = (31 + k < ND) ? d[k] : 1'b0;
      end else if (a >= 4) begin
         idx = (int'(a) - 4) / 2;
         if (idx < NR && !bml[idx]) begin
            if (a[0] == 1'b0) begin
               for (int j = 0; j < 31; j++) if (j < ND && !c0[j]) bm[idx][j] = d[j];
               if (d[31]) bml[idx] = 1'b1;
            end else begin
               for (int k = 0; k < 32; k++) if (31 + k < ND && !c0[31+k]) bm[idx][31+k] = d[k];
            end
         end
         if (idx < ND && !c1[idx]) begin
            for (int b = 0; b < 32; b++) begin
               if (a[0]) pm[idx][32+b] = d[b];
               else      pm[idx][b]    = d[b];
            end
         end
      end
   endtask

   task automatic compare(string tag, int i, logic [151:0] act, logic [151:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s u%0d: got %h expected %h", tag, i, act, exp);
      end
   endtask

   // one clock: expectations come from the model state before this cycle's write
   task automatic cycle(string tag, bit w, logic [7:0] a, logic [31:0] d,
                        logic [7:0] r, logic [15:0] s);
      logic [151:0] e [3];
      logic [ND-1:0] m, gr, gw;
      we = w; wa = a; wd = d; ra = r; rid = s;
      // bitmap
      m = (int'(s) < NR) ? bm[s][ND-1:0] : '0;
      e[0] = {exp_rd(0, r), m, m, m};
      // permission
      for (int k = 0; k < ND; k++) begin
         gr[k] = (int'(s) < NR) ? pm[k][2*int'(s)]     : 1'b0;
         gw[k] = (int'(s) < NR) ? pm[k][2*int'(s) + 1] : 1'b0;
      end
      e[1] = {exp_rd(2, r), gr | gw, gr, gw};
      // direct
      m = '0;
      if (int'(s) < NR && int'(s) < ND) m[s] = 1'b1;
      e[2] = {32'b0, m, m, m};
      if (w) model_write(a, d);
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < 3; i++) compare(tag, i, {rdat[i], omask[i], ord[i], owr[i]}, e[i]);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin bm[i] = '0; bml[i] = 1'b0; end
      for (int i = 0; i < ND; i++) pm[i] = '0;
      c0 = '0; c1 = '0; c0l = 1'b0; c1l = 1'b0;
      rst_n = 1'b0; we = 1'b0; wa = '0; wd = '0; ra = '0; rid = '0;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero while in reset
      for (int i = 0; i < 3; i++) compare("R1", i, {rdat[i], omask[i], ord[i], owr[i]}, '0);
      rst_n = 1'b1;

      cycle("R1", 0, 0, 0, 0, 0);
      cycle("R1", 0, 0, 0, 5, 3);

      // R2 and R11: write row 3 while reading and looking it up in the same cycle
      cycle("R2", 1, 10, 32'h0000_A5A5, 10, 3);
      cycle("R11", 1, 11, 32'h0000_00FF, 10, 3);
      cycle("R2", 0, 0, 0, 11, 3);
      cycle("R2", 0, 0, 0, 0, 3);

      // R3: high word all ones, only domains below 40 survive
      cycle("R3", 1, 15, 32'hFFFF_FFFF, 15, 5);
      cycle("R3", 0, 0, 0, 15, 5);

      // R5: permission bit positions
      cycle("R5", 1, 18, 32'h0000_0006, 0, 0);
      cycle("R5", 1, 19, 32'h0000_0001, 18, 1);
      cycle("R5", 0, 0, 0, 19, 16);
      cycle("R5", 1, 19, 32'h8000_0001, 0, 0);
      cycle("R5", 0, 0, 0, 19, 31);
      cycle("R5", 0, 0, 0, 18, 16);

      // R6: column lock on domain 3, then try to clear it
      cycle("R6", 1, 0, 32'h0000_0010, 0, 3);
      cycle("R6", 1, 10, 32'h0, 1, 3);
      cycle("R6", 0, 0, 0, 10, 3);
      cycle("R6", 1, 11, 32'h0, 11, 3);
      cycle("R6", 0, 0, 0, 11, 3);

      // R7 and R8: freeze the column lock
      cycle("R7", 1, 1, 32'h0000_0100, 1, 0);
      cycle("R7", 1, 0, 32'h0000_0011, 0, 0);
      cycle("R8", 1, 0, 32'h0, 0, 0);
      cycle("R7", 1, 1, 32'h0, 1, 0);
      cycle("R7", 0, 0, 0, 0, 0);
      cycle("R7", 0, 0, 0, 1, 0);
      cycle("R6", 1, 11, 32'h0000_FFFF, 11, 3);
      cycle("R6", 0, 0, 0, 11, 3);

      // R4 and R8: row lock on row 9
      cycle("R4", 1, 22, 32'h8000_000F, 22, 9);
      cycle("R4", 1, 22, 32'h0, 22, 9);
      cycle("R8", 1, 23, 32'h0000_00FF, 22, 9);
      cycle("R4", 0, 0, 0, 23, 9);
      cycle("R4", 0, 0, 0, 22, 9);

      // R10 and R11: out-of-range IDs, reserved and out-of-table words
      cycle("R10", 0, 0, 0, 2, 32);
      cycle("R10", 0, 0, 0, 3, 100);
      cycle("R10", 0, 0, 0, 200, 16'hFFFF);
      cycle("R10", 0, 0, 0, 90, 39);
      cycle("R10", 0, 0, 0, 68, 40);

      // R9: direct layout over all IDs
      for (int s = 0; s < NR; s++) cycle("R9", 0, 0, 0, 8'(4 + 2 * s), 16'(s));

      // R11: mixed random traffic
      for (int n = 0; n < 400; n++) begin
         logic [7:0] a;
         a = 8'($urandom_range(0, 92));
         cycle("R11", 1'($urandom_range(0, 1)), a, $urandom(),
               8'($urandom_range(0, 92)), 16'($urandom_range(0, 45)));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule